// File: doc/BRIEF.md
# Load/Store Byte-Lane Alignment Unit

This block sits between a core's load/store pipeline stage and a data memory that is one 32-bit word wide. On the store side it accepts the source register value, an access size and the two low address bits. It returns write data copied into every lane of the access size, together with a four-bit byte-enable mask that picks out only the bytes the access touches. On the load side it accepts the word read from memory. It picks out the addressed byte or halfword and extends it to full width with either sign or zero fill. A word load passes the word through unchanged.

Lanes are numbered big-endian: address offset 0 is the most significant byte, bits 31:24. The unit does not handle an access that is not aligned to its own size. It raises a flag instead, and that flag keeps the access from reaching memory. Both paths are registered once, so every result appears one clock after its request. Address generation and the memory itself belong to the surrounding logic.

Top module: `lane_align_unit`

## Requirements
- R1: While reset is active and on the first cycle after it, every output is zero: both valid flags, both misalign flags, the byte enables, the write data and the load result.
- R2: A request presented with its valid input high at a rising clock edge produces its result, with the matching output valid high, right after that edge. The latency is one cycle.
- R3: Size encoding is 00 = byte, 01 = halfword, 10 or 11 = word. A byte store at offset k (0..3) drives byte enable 4'b1000 >> k. The write data is the source's bits 7:0 copied into all four lanes.
- R4: A halfword store at offset 0 drives byte enable 4'b1100, and at offset 2 it drives 4'b0011. The write data is the source's bits 15:0 copied into both halves.
- R5: An aligned word store drives byte enable 4'b1111, and the write data equals the source unchanged.
- R6: A halfword access with offset bit 0 set, or a word access with a nonzero offset, raises the misalign output for that path. The result is byte enable 4'b0000 for a store and a load result of zero for a load. Byte accesses never raise it.
- R7: A byte load with the signed input at 1 returns the addressed byte, taken big-endian, with bit 7 copied into bits 31:8.
- R8: A byte load with the signed input at 0 returns the addressed byte with bits 31:8 cleared.
- R9: A halfword load returns bits 31:16 at offset 0 or bits 15:0 at offset 2. The signed input chooses sign or zero extension.
- R10: An aligned word load returns the memory word unchanged, whatever the signed input is.
- R11: With a path's valid input low at a clock edge, that path's outputs after the edge are all zero: valid, misalign, byte enables and data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_req | input | 1 | Store request valid |
| st_size | input | 2 | Store size: 00 byte, 01 halfword, 1x word |
| st_off | input | 2 | Low address bits of the store |
| st_src | input | 32 | Store source register value |
| ld_req | input | 1 | Load request valid |
| ld_size | input | 2 | Load size: 00 byte, 01 halfword, 1x word |
| ld_sext | input | 1 | 1 = sign-extend, 0 = zero-extend |
| ld_off | input | 2 | Low address bits of the load |
| ld_mem | input | 32 | Word returned by memory |
| st_ack | output | 1 | Store result valid |
| st_wdata | output | 32 | Lane-replicated write data |
| st_be | output | 4 | Byte enables, bit 3 = offset 0 |
| st_misal | output | 1 | Store misaligned |
| ld_ack | output | 1 | Load result valid |
| ld_data | output | 32 | Extended load result |
| ld_misal | output | 1 | Load misaligned |

## Verification
The hardest case to reach is a request that is misaligned on one path arriving in the same cycle as a well-formed request on the other path. It also has to land directly after an aligned access whose enables are still on the outputs. The directed tasks drive both paths at once and issue each misaligned access right after a valid one. This shows the enables drop to zero within one cycle and that the flag on one path does not leak into the other. A second hard case is sign extension from each lane, which needs a negative byte sitting in a different lane from the bytes around it. The load tasks therefore put a distinct pattern in every lane of the memory word.

// File: rtl/lane_align_pkg.sv
package lane_align_pkg;

    localparam int unsigned BYTE_W = 8;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'b00,
        SZ_HALF  = 2'b01,
        SZ_WORD  = 2'b10,
        SZ_WORD2 = 2'b11
    } acc_size_e;

    function automatic logic is_byte(input logic [1:0] sz);
        return sz == SZ_BYTE;
    endfunction

    function automatic logic is_half(input logic [1:0] sz);
        return sz == SZ_HALF;
    endfunction

    function automatic logic is_word(input logic [1:0] sz);
        return sz[1];
    endfunction

endpackage

// File: rtl/lane_misalign_check.sv
module lane_misalign_check
    import lane_align_pkg::*;
#(
    parameter int unsigned OFF_W = 2
) (
    input  logic [1:0]       size_i,
    input  logic [OFF_W-1:0] off_i,
    output logic             misal_o
);

    logic half_bad;
    logic word_bad;

    always_comb begin
        half_bad = is_half(size_i) && off_i[0];
        word_bad = is_word(size_i) && (off_i != '0);
        misal_o  = half_bad || word_bad;
    end

endmodule

// File: rtl/store_lane_pack.sv
module store_lane_pack
    import lane_align_pkg::*;
#(
    parameter int unsigned WORD_W = 32
) (
    input  logic [1:0]               size_i,
    input  logic [$clog2(WORD_W/BYTE_W)-1:0] off_i,
    input  logic [WORD_W-1:0]        src_i,
    input  logic                     misal_i,
    output logic [WORD_W-1:0]        wdata_o,
    output logic [WORD_W/BYTE_W-1:0] be_o
);

    localparam int unsigned LANES = WORD_W / BYTE_W;
    localparam int unsigned OFF_W = $clog2(LANES);

    // Lane i counts from the most significant byte (big-endian offset i).
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        localparam int unsigned HI    = WORD_W - 1 - i * BYTE_W;
        localparam int unsigned HSEL  = i / 2;
        localparam int unsigned HPART = i % 2;

        logic [BYTE_W-1:0] lane_data;
        logic              lane_hit;

        always_comb begin
            if (is_byte(size_i)) begin
                lane_data = src_i[BYTE_W-1:0];
                lane_hit  = (off_i == OFF_W'(i));
            end else if (is_half(size_i)) begin
                lane_data = (HPART == 0) ? src_i[2*BYTE_W-1:BYTE_W]
                                         : src_i[BYTE_W-1:0];
                lane_hit  = (off_i[OFF_W-1:1] == (OFF_W-1)'(HSEL));
            end else begin
                lane_data = src_i[HI -: BYTE_W];
                lane_hit  = 1'b1;
            end
        end

        assign wdata_o[HI -: BYTE_W] = lane_data;
        assign be_o[LANES-1-i]       = lane_hit && !misal_i;
    end

endmodule

// File: rtl/load_lane_extract.sv
module load_lane_extract
    import lane_align_pkg::*;
#(
    parameter int unsigned WORD_W = 32
) (
    input  logic [1:0]                       size_i,
    input  logic                             sext_i,
    input  logic [$clog2(WORD_W/BYTE_W)-1:0] off_i,
    input  logic [WORD_W-1:0]                mem_i,
    input  logic                             misal_i,
    output logic [WORD_W-1:0]                data_o
);

    localparam int unsigned LANES = WORD_W / BYTE_W;
    localparam int unsigned OFF_W = $clog2(LANES);
    localparam int unsigned HALF_W = 2 * BYTE_W;

    logic [BYTE_W-1:0] lane_b [LANES];

    for (genvar i = 0; i < LANES; i++) begin : g_split
        assign lane_b[i] = mem_i[WORD_W-1-i*BYTE_W -: BYTE_W];
    end

    logic [BYTE_W-1:0] byte_sel;
    logic [HALF_W-1:0] half_sel;
    logic [OFF_W-1:0]  half_hi_idx;
    logic [OFF_W-1:0]  half_lo_idx;

    always_comb begin
        half_hi_idx = {off_i[OFF_W-1:1], 1'b0};
        half_lo_idx = {off_i[OFF_W-1:1], 1'b1};
        byte_sel    = lane_b[off_i];
        half_sel    = {lane_b[half_hi_idx], lane_b[half_lo_idx]};

        if (misal_i) begin
            data_o = '0;
        end else if (is_byte(size_i)) begin
            data_o = {{(WORD_W-BYTE_W){sext_i & byte_sel[BYTE_W-1]}}, byte_sel};
        end else if (is_half(size_i)) begin
            data_o = {{(WORD_W-HALF_W){sext_i & half_sel[HALF_W-1]}}, half_sel};
        end else begin
            data_o = mem_i;
        end
    end

endmodule

// File: rtl/lane_align_unit.sv
module lane_align_unit
    import lane_align_pkg::*;
#(
    parameter int unsigned WORD_W = 32,
    localparam int unsigned LANES = WORD_W / BYTE_W,
    localparam int unsigned OFF_W = $clog2(LANES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              st_req,
    input  logic [1:0]        st_size,
    input  logic [OFF_W-1:0]  st_off,
    input  logic [WORD_W-1:0] st_src,
    input  logic              ld_req,
    input  logic [1:0]        ld_size,
    input  logic              ld_sext,
    input  logic [OFF_W-1:0]  ld_off,
    input  logic [WORD_W-1:0] ld_mem,
    output logic              st_ack,
    output logic [WORD_W-1:0] st_wdata,
    output logic [LANES-1:0]  st_be,
    output logic              st_misal,
    output logic              ld_ack,
    output logic [WORD_W-1:0] ld_data,
    output logic              ld_misal
);

    typedef struct packed {
        logic              ack;
        logic              misal;
        logic [LANES-1:0]  be;
        logic [WORD_W-1:0] wdata;
    } st_stage_t;

    typedef struct packed {
        logic              ack;
        logic              misal;
        logic [WORD_W-1:0] data;
    } ld_stage_t;

    typedef struct packed {
        st_stage_t st;
        ld_stage_t ld;
    } stage_t;

    stage_t stage_d, stage_q;

    logic              st_misal_c, ld_misal_c;
    logic [WORD_W-1:0] st_wdata_c, ld_data_c;
    logic [LANES-1:0]  st_be_c;

    lane_misalign_check #(.OFF_W(OFF_W)) st_chk_i (
        .size_i (st_size),
        .off_i  (st_off),
        .misal_o(st_misal_c)
    );

    lane_misalign_check #(.OFF_W(OFF_W)) ld_chk_i (
        .size_i (ld_size),
        .off_i  (ld_off),
        .misal_o(ld_misal_c)
    );

    store_lane_pack #(.WORD_W(WORD_W)) st_pack_i (
        .size_i (st_size),
        .off_i  (st_off),
        .src_i  (st_src),
        .misal_i(st_misal_c),
        .wdata_o(st_wdata_c),
        .be_o   (st_be_c)
    );

    load_lane_extract #(.WORD_W(WORD_W)) ld_ext_i (
        .size_i (ld_size),
        .sext_i (ld_sext),
        .off_i  (ld_off),
        .mem_i  (ld_mem),
        .misal_i(ld_misal_c),
        .data_o (ld_data_c)
    );

    always_comb begin
        stage_d = '0;
        if (st_req) begin
            stage_d.st.ack   = 1'b1;
            stage_d.st.misal = st_misal_c;
            stage_d.st.be    = st_be_c;
            stage_d.st.wdata = st_wdata_c;
        end
        if (ld_req) begin
            stage_d.ld.ack   = 1'b1;
            stage_d.ld.misal = ld_misal_c;
            stage_d.ld.data  = ld_data_c;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q <= '0;
        end else begin
            stage_q <= stage_d;
        end
    end

    assign st_ack   = stage_q.st.ack;
    assign st_misal = stage_q.st.misal;
    assign st_be    = stage_q.st.be;
    assign st_wdata = stage_q.st.wdata;
    assign ld_ack   = stage_q.ld.ack;
    assign ld_misal = stage_q.ld.misal;
    assign ld_data  = stage_q.ld.data;

    // R3: an accepted byte store enables exactly one lane
    a_r3_byte_one_lane: assert property (@(posedge clk) disable iff (!rst_n)
        (st_req && st_size == SZ_BYTE) |=> ($countones(st_be) == 1));

    // R4: an aligned halfword store enables exactly two lanes
    a_r4_half_two_lanes: assert property (@(posedge clk) disable iff (!rst_n)
        (st_req && st_size == SZ_HALF && !st_off[0]) |=> ($countones(st_be) == 2));

    // R6: a flagged store never enables any lane
    a_r6_misal_no_be: assert property (@(posedge clk) disable iff (!rst_n)
        st_misal |-> (st_be == '0));

    // R6: a flagged load returns zero
    a_r6_misal_ld_zero: assert property (@(posedge clk) disable iff (!rst_n)
        ld_misal |-> (ld_data == '0));

    // R10: aligned word load is a pass-through of the memory word
    a_r10_word_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_req && ld_size[1] && ld_off == '0) |=> (ld_data == $past(ld_mem)));

    // R11: an idle store cycle leaves no enables behind
    a_r11_idle_st: assert property (@(posedge clk) disable iff (!rst_n)
        !st_req |=> (!st_ack && st_be == '0));

    // R11: an idle load cycle leaves no result behind
    a_r11_idle_ld: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_req |=> (!ld_ack && ld_data == '0));

endmodule

// File: tb/lane_align_unit_tb.sv
module lane_align_unit_tb_top;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        st_req = 1'b0;
    logic [1:0]  st_size = '0;
    logic [1:0]  st_off = '0;
    logic [31:0] st_src = '0;
    logic        ld_req = 1'b0;
    logic [1:0]  ld_size = '0;
    logic        ld_sext = 1'b0;
    logic [1:0]  ld_off = '0;
    logic [31:0] ld_mem = '0;
    logic        st_ack, st_misal, ld_ack, ld_misal;
    logic [31:0] st_wdata, ld_data;
    logic [3:0]  st_be;

    int n_checks = 0;
    int n_errs   = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lane_align_unit dut_i (
        .clk(clk), .rst_n(rst_n),
        .st_req(st_req), .st_size(st_size), .st_off(st_off), .st_src(st_src),
        .ld_req(ld_req), .ld_size(ld_size), .ld_sext(ld_sext), .ld_off(ld_off),
        .ld_mem(ld_mem),
        .st_ack(st_ack), .st_wdata(st_wdata), .st_be(st_be), .st_misal(st_misal),
        .ld_ack(ld_ack), .ld_data(ld_data), .ld_misal(ld_misal)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errs++;
            $display("FAIL %s: actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    // drive at a falling edge, sample at the next falling edge (one register)
    task automatic step();
        @(negedge clk);
    endtask

    task automatic put_st(input logic [1:0] sz, input logic [1:0] off, input logic [31:0] src);
        st_req = 1'b1; st_size = sz; st_off = off; st_src = src;
    endtask

    task automatic put_ld(input logic [1:0] sz, input logic sx, input logic [1:0] off,
                          input logic [31:0] mem);
        ld_req = 1'b1; ld_size = sz; ld_sext = sx; ld_off = off; ld_mem = mem;
    endtask

    task automatic idle();
        st_req = 1'b0; ld_req = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        put_st(2'b10, 2'b00, 32'hFFFF_FFFF);
        put_ld(2'b10, 1'b1, 2'b00, 32'hFFFF_FFFF);
        repeat (3) step();
        check("R1 st_ack", {31'd0, st_ack}, 0);
        check("R1 st_be", {28'd0, st_be}, 0);
        check("R1 st_wdata", st_wdata, 0);
        check("R1 ld_data", ld_data, 0);
        check("R1 flags", {29'd0, ld_ack, ld_misal, st_misal}, 0);
        idle();
        rst_n = 1'b1;
        step();
        check("R1 first cycle idle", {28'd0, st_be}, 0);
    endtask

    task automatic t_store_byte();
        for (int k = 0; k < 4; k++) begin
            put_st(2'b00, 2'(k), 32'h1234_56A5);
            step();
            check("R2 st_ack", {31'd0, st_ack}, 1);
            check("R3 byte be", {28'd0, st_be}, {28'd0, 4'b1000 >> k});
            check("R3 byte wdata", st_wdata, 32'hA5A5_A5A5);
            check("R6 byte never misal", {31'd0, st_misal}, 0);
        end
    endtask

    task automatic t_store_half();
        put_st(2'b01, 2'd0, 32'hDEAD_BEEF);
        step();
        check("R4 half off0 be", {28'd0, st_be}, 32'h0000_000C);
        check("R4 half wdata", st_wdata, 32'hBEEF_BEEF);
        put_st(2'b01, 2'd2, 32'h0000_1357);
        step();
        check("R4 half off2 be", {28'd0, st_be}, 32'h0000_0003);
        check("R4 half wdata2", st_wdata, 32'h1357_1357);
    endtask

    task automatic t_store_word();
        put_st(2'b10, 2'd0, 32'hCAFE_F00D);
        step();
        check("R5 word be", {28'd0, st_be}, 32'hF);
        check("R5 word wdata", st_wdata, 32'hCAFE_F00D);
        put_st(2'b11, 2'd0, 32'h0102_0304);
        step();
        check("R5 word alt code be", {28'd0, st_be}, 32'hF);
    endtask

    task automatic t_misalign();
        // misaligned store beside an aligned load, right after a full-enable store
        put_st(2'b10, 2'd0, 32'h1111_1111);
        step();
        put_st(2'b01, 2'd1, 32'h2222_2222);
        put_ld(2'b10, 1'b0, 2'd0, 32'h8765_4321);
        step();
        check("R6 half st misal", {31'd0, st_misal}, 1);
        check("R6 half st be", {28'd0, st_be}, 0);
        check("R6 ld not flagged", {31'd0, ld_misal}, 0);
        check("R6 ld unaffected", ld_data, 32'h8765_4321);
        for (int k = 1; k < 4; k++) begin
            put_st(2'b10, 2'(k), 32'h3333_3333);
            put_ld(2'b10, 1'b0, 2'(k), 32'h4444_4444);
            step();
            check("R6 word st misal", {31'd0, st_misal}, 1);
            check("R6 word st be", {28'd0, st_be}, 0);
            check("R6 word ld misal", {31'd0, ld_misal}, 1);
            check("R6 word ld zero", ld_data, 0);
        end
        put_ld(2'b01, 1'b1, 2'd3, 32'hFFFF_FFFF);
        put_st(2'b00, 2'd3, 32'h0000_0077);
        step();
        check("R6 half ld misal", {31'd0, ld_misal}, 1);
        check("R6 half ld zero", ld_data, 0);
        check("R6 byte st ok", {28'd0, st_be}, 32'h1);
        idle();
    endtask

    task automatic t_load_byte();
        logic [31:0] mem;
        logic [7:0]  b;
        mem = 32'h80_7F_C3_05;
        for (int k = 0; k < 4; k++) begin
            b = mem[31 - 8*k -: 8];
            put_ld(2'b00, 1'b1, 2'(k), mem);
            step();
            check("R2 ld_ack", {31'd0, ld_ack}, 1);
            check("R7 signed byte", ld_data, {{24{b[7]}}, b});
            put_ld(2'b00, 1'b0, 2'(k), mem);
            step();
            check("R8 unsigned byte", ld_data, {24'd0, b});
        end
    endtask

    task automatic t_load_half();
        put_ld(2'b01, 1'b1, 2'd0, 32'h9ABC_1234);
        step();
        check("R9 half off0 signed", ld_data, 32'hFFFF_9ABC);
        put_ld(2'b01, 1'b0, 2'd0, 32'h9ABC_1234);
        step();
        check("R9 half off0 unsigned", ld_data, 32'h0000_9ABC);
        put_ld(2'b01, 1'b1, 2'd2, 32'h1234_F00F);
        step();
        check("R9 half off2 signed", ld_data, 32'hFFFF_F00F);
        put_ld(2'b01, 1'b1, 2'd2, 32'hF00F_7123);
        step();
        check("R9 half off2 positive", ld_data, 32'h0000_7123);
    endtask

    task automatic t_load_word();
        put_ld(2'b10, 1'b1, 2'd0, 32'h8000_00FF);
        step();
        check("R10 word signed in", ld_data, 32'h8000_00FF);
        put_ld(2'b11, 1'b0, 2'd0, 32'h7F00_8001);
        step();
        check("R10 word alt code", ld_data, 32'h7F00_8001);
    endtask

    task automatic t_idle();
        put_st(2'b10, 2'd0, 32'h5555_AAAA);
        put_ld(2'b10, 1'b0, 2'd0, 32'h5555_AAAA);
        step();
        idle();
        st_src = 32'hFFFF_FFFF;
        ld_mem = 32'hFFFF_FFFF;
        step();
        check("R11 st_ack low", {31'd0, st_ack}, 0);
        check("R11 be zero", {28'd0, st_be}, 0);
        check("R11 wdata zero", st_wdata, 0);
        check("R11 ld_ack low", {31'd0, ld_ack}, 0);
        check("R11 ld_data zero", ld_data, 0);
    endtask

    initial begin
        t_reset();
        t_store_byte();
        t_store_half();
        t_store_word();
        t_misalign();
        t_load_byte();
        t_load_half();
        t_load_word();
        t_idle();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 5000);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_errs++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
            $finish;
        end
    end

endmodule